// File: doc/BRIEF.md
# Block Transfer, Search and Port Burst Sequencer

This block carries out the repeating byte-block operations of an 8-bit CPU core with 16-bit addressing. A caller loads the pointer pair (source and destination), the 16-bit count, the accumulator byte and an operation selector, then pulses `start`. The sequencer runs every iteration internally, two clock cycles per byte. It uses a single byte-wide memory port and an I/O port with 8-bit data. It keeps a running total of the CPU time states the sequence would take. At the end it raises `done` for one cycle, and holds the final pointer, count, match and count-zero values on its outputs until the next start.

Four families are supported, each in single and repeating form, stepping upward or downward. A copy moves a byte from the source pointer to the destination pointer. A search compares the accumulator against the byte at the source pointer and never writes. A port input stores a port byte at the source pointer. A port output sends the byte at the source pointer to a port. Port operations address the port with the full 16-bit count register and count down only its upper byte.

Top module: `blk_engine`

## Requirements
- R1: After synchronous reset `busy`, `done`, all four port strobes and `tstates` are low or zero.
- R2: Copy (op=0) reads the byte at `hl`, writes it at `de`, moves `hl` and `de` by +1 (`dec`=0) or -1 (`dec`=1), and lowers `bc` by one.
- R3: With `rpt`=1, copy keeps iterating until `bc` reaches zero. With `rpt`=0 it runs exactly one iteration.
- R4: `tstates` starts from zero on each start. Each iteration adds 21 when another iteration follows and 16 when it is the last one.
- R5: Search (op=1) compares `a_in` with the byte at `hl`, moves `hl`, lowers `bc`, and never writes. The repeating form stops on a match or when `bc` reaches zero. `match` shows whether the last byte compared equal.
- R6: Port input (op=2) reads the port at address `bc` (upper byte value before the decrement), stores the byte at `hl`, moves `hl`, and lowers only `bc[15:8]`. The repeating form stops when `bc[15:8]` reaches zero.
- R7: Port output (op=3) reads the byte at `hl`, writes it to the port at address `bc` (value before the decrement), moves `hl`, and lowers only `bc[15:8]`, with the same stop rule as R6.
- R8: Pointer stepping wraps modulo 65536 in both directions.
- R9: A start with count 0 runs 65536 iterations (256 for port forms), following wrap-around.
- R10: `done` is high for exactly one cycle after the last iteration. `cnt_zero` is high when the count that governs the operation (full `bc`, or `bc[15:8]` for port forms) ended at zero.
- R11: A `start` pulse while the sequencer is busy is ignored and leaves the running operation unchanged.
- R12: At most one of `mem_rd`, `mem_wr`, `io_rd`, `io_wr` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when idle |
| op | input | 2 | 0 copy, 1 search, 2 port input, 3 port output |
| dec | input | 1 | 1 steps pointers downward |
| rpt | input | 1 | 1 selects the repeating form |
| hl_in | input | 16 | Initial source pointer |
| de_in | input | 16 | Initial destination pointer |
| bc_in | input | 16 | Initial count / port address |
| a_in | input | 8 | Accumulator byte for search |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Memory read data, valid in the strobe cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| io_addr | output | 16 | Port address |
| io_rd | output | 1 | Port read strobe |
| io_rdata | input | 8 | Port read data, valid in the strobe cycle |
| io_wr | output | 1 | Port write strobe |
| io_wdata | output | 8 | Port write data |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| hl_out | output | 16 | Current / final source pointer |
| de_out | output | 16 | Current / final destination pointer |
| bc_out | output | 16 | Current / final count |
| match | output | 1 | Last search byte matched |
| cnt_zero | output | 1 | Governing count ended at zero |
| tstates | output | 24 | Accumulated time-state total |

## Verification
The bound checker watches several rules on every cycle. It checks strobe exclusivity, the single-cycle `done` pulse and silent ports while idle. It checks that search never writes, that every port access uses the live count register as its address, and that the time-state total grows only by 0, 16 or 21 per cycle while busy. Byte movement, stop conditions, pointer wrap, the 65536-iteration zero-count run and the exact final totals are only visible to the bench. The bench compares memory contents, port logs and final outputs against its own model after each operation.

// File: rtl/blk_pkg.sv
package blk_pkg;
    localparam int AW        = 16;
    localparam int DW        = 8;
    localparam int BW        = AW - DW;
    localparam int CYC_W     = 24;
    localparam int COST_LAST = 16;
    localparam int COST_MORE = COST_LAST + 5;

    typedef enum logic [1:0] {
        OP_COPY   = 2'd0,
        OP_SEARCH = 2'd1,
        OP_IN     = 2'd2,
        OP_OUT    = 2'd3
    } blk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STORE,
        ST_DONE
    } blk_st_e;

    typedef struct packed {
        logic [AW-1:0] hl;
        logic [AW-1:0] de;
        logic [AW-1:0] bc;
    } blk_regs_t;

    function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic down);
        return down ? a - AW'(1) : a + AW'(1);
    endfunction

    function automatic logic is_port_op(input blk_op_e o);
        return (o == OP_IN) || (o == OP_OUT);
    endfunction
endpackage

// File: rtl/blk_stepper.sv
module blk_stepper
    import blk_pkg::*;
(
    input  blk_op_e   op,
    input  logic      dec,
    input  blk_regs_t cur,
    output blk_regs_t nxt
);
    always_comb begin
        nxt    = cur;
        nxt.hl = step_addr(cur.hl, dec);
        if (is_port_op(op)) begin
            nxt.bc = {cur.bc[AW-1:DW] - BW'(1), cur.bc[DW-1:0]};
        end else begin
            nxt.bc = cur.bc - AW'(1);
        end
        if (op == OP_COPY) begin
            nxt.de = step_addr(cur.de, dec);
        end
    end
endmodule

// File: rtl/blk_term.sv
module blk_term
    import blk_pkg::*;
(
    input  blk_op_e       op,
    input  logic          rpt,
    input  logic [AW-1:0] bc_next,
    input  logic [DW-1:0] acc,
    input  logic [DW-1:0] data,
    output logic          hit,
    output logic          cnt_zero,
    output logic          more
);
    always_comb begin
        hit      = (op == OP_SEARCH) && (acc == data);
        cnt_zero = is_port_op(op) ? (bc_next[AW-1:DW] == '0) : (bc_next == '0);
        more     = rpt && !cnt_zero && !hit;
    end
endmodule

// File: rtl/blk_tally.sv
module blk_tally
    import blk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             add,
    input  logic             more,
    output logic [CYC_W-1:0] total
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            total <= '0;
        end else if (add) begin
            total <= total + (more ? CYC_W'(COST_MORE) : CYC_W'(COST_LAST));
        end
    end
endmodule

// File: rtl/blk_engine.sv
module blk_engine
    import blk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [1:0]       op,
    input  logic             dec,
    input  logic             rpt,
    input  logic [AW-1:0]    hl_in,
    input  logic [AW-1:0]    de_in,
    input  logic [AW-1:0]    bc_in,
    input  logic [DW-1:0]    a_in,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_rd,
    input  logic [DW-1:0]    mem_rdata,
    output logic             mem_wr,
    output logic [DW-1:0]    mem_wdata,
    output logic [AW-1:0]    io_addr,
    output logic             io_rd,
    input  logic [DW-1:0]    io_rdata,
    output logic             io_wr,
    output logic [DW-1:0]    io_wdata,
    output logic             busy,
    output logic             done,
    output logic [AW-1:0]    hl_out,
    output logic [AW-1:0]    de_out,
    output logic [AW-1:0]    bc_out,
    output logic             match,
    output logic             cnt_zero,
    output logic [CYC_W-1:0] tstates
);
    blk_st_e       st;
    blk_op_e       op_q;
    logic          dec_q, rpt_q;
    blk_regs_t     r, r_nx;
    logic [DW-1:0] a_q, dbuf;
    logic          hit_q, cz_q;
    logic          hit, cz, more;
    logic          launch, store_go;

    assign launch   = start && (st == ST_IDLE);
    assign store_go = (st == ST_STORE);

    blk_stepper u_step (
        .op  (op_q),
        .dec (dec_q),
        .cur (r),
        .nxt (r_nx)
    );

    blk_term u_term (
        .op       (op_q),
        .rpt      (rpt_q),
        .bc_next  (r_nx.bc),
        .acc      (a_q),
        .data     (dbuf),
        .hit      (hit),
        .cnt_zero (cz),
        .more     (more)
    );

    blk_tally u_tally (
        .clk   (clk),
        .rst   (rst),
        .clr   (launch),
        .add   (store_go),
        .more  (more),
        .total (tstates)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            op_q  <= OP_COPY;
            dec_q <= 1'b0;
            rpt_q <= 1'b0;
            r     <= '0;
            a_q   <= '0;
            dbuf  <= '0;
            hit_q <= 1'b0;
            cz_q  <= 1'b0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (launch) begin
                        op_q  <= blk_op_e'(op);
                        dec_q <= dec;
                        rpt_q <= rpt;
                        r     <= '{hl: hl_in, de: de_in, bc: bc_in};
                        a_q   <= a_in;
                        hit_q <= 1'b0;
                        cz_q  <= 1'b0;
                        st    <= ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    dbuf <= (op_q == OP_IN) ? io_rdata : mem_rdata;
                    st   <= ST_STORE;
                end
                ST_STORE: begin
                    r     <= r_nx;
                    hit_q <= hit;
                    cz_q  <= cz;
                    st    <= more ? ST_FETCH : ST_DONE;
                end
                ST_DONE: st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_addr  = r.hl;
        mem_rd    = 1'b0;
        mem_wr    = 1'b0;
        mem_wdata = dbuf;
        io_addr   = r.bc;
        io_rd     = 1'b0;
        io_wr     = 1'b0;
        io_wdata  = dbuf;
        if (st == ST_FETCH) begin
            if (op_q == OP_IN) io_rd = 1'b1;
            else               mem_rd = 1'b1;
        end else if (st == ST_STORE) begin
            unique case (op_q)
                OP_COPY: begin
                    mem_addr = r.de;
                    mem_wr   = 1'b1;
                end
                OP_IN:   mem_wr = 1'b1;
                OP_OUT:  io_wr  = 1'b1;
                default: ;
            endcase
        end
    end

    assign busy     = (st == ST_FETCH) || (st == ST_STORE);
    assign done     = (st == ST_DONE);
    assign hl_out   = r.hl;
    assign de_out   = r.de;
    assign bc_out   = r.bc;
    assign match    = hit_q;
    assign cnt_zero = cz_q;
endmodule

// File: rtl/blk_engine_chk.sv
module blk_engine_chk
    import blk_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [1:0]       op,
    input logic             busy,
    input logic             done,
    input logic             mem_rd,
    input logic             mem_wr,
    input logic             io_rd,
    input logic             io_wr,
    input logic [AW-1:0]    io_addr,
    input logic [AW-1:0]    bc_out,
    input logic [CYC_W-1:0] tstates
);
    logic [1:0]       op_l;
    logic [CYC_W-1:0] prev_t;
    logic [CYC_W-1:0] delta;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_l   <= '0;
            prev_t <= '0;
        end else begin
            if (start && !busy && !done) op_l <= op;
            prev_t <= tstates;
        end
    end

    assign delta = tstates - prev_t;

    // R12
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr, io_rd, io_wr}));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(mem_rd || mem_wr || io_rd || io_wr));

    // R5
    search_nowrite_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && op_l == 2'd1) |-> !(mem_wr || io_rd || io_wr));

    // R6
    port_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (io_rd || io_wr) |-> io_addr == bc_out);

    // R4
    cost_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |->
            (delta == '0 || delta == CYC_W'(COST_LAST) || delta == CYC_W'(COST_MORE)));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));
endmodule

bind blk_engine blk_engine_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .op      (op),
    .busy    (busy),
    .done    (done),
    .mem_rd  (mem_rd),
    .mem_wr  (mem_wr),
    .io_rd   (io_rd),
    .io_wr   (io_wr),
    .io_addr (io_addr),
    .bc_out  (bc_out),
    .tstates (tstates)
);

// File: tb/blk_engine_test.sv
module blk_engine_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [1:0]  op = '0;
    logic        dec = 1'b0, rpt = 1'b0;
    logic [15:0] hl_in = '0, de_in = '0, bc_in = '0;
    logic [7:0]  a_in = '0;
    logic [15:0] mem_addr, io_addr, hl_out, de_out, bc_out;
    logic        mem_rd, mem_wr, io_rd, io_wr, busy, done, match, cnt_zero;
    logic [7:0]  mem_rdata, mem_wdata, io_rdata, io_wdata;
    logic [23:0] tstates;

    logic [7:0]  mem     [0:4095];
    logic [7:0]  ref_mem [0:4095];
    logic [15:0] port_log [0:511];
    logic [7:0]  data_log [0:511];
    logic [15:0] exp_port [0:511];
    logic [7:0]  exp_data [0:511];
    int          io_n, rd_idx, multi_strobe, cyc;
    logic        log_clr = 1'b0;
    int          checks = 0, failures = 0;

    logic [15:0] e_hl, e_de, e_bc;
    logic        e_match, e_cz;
    logic [23:0] e_t;
    int          e_n;

    blk_engine uut (
        .clk(clk), .rst(rst), .start(start), .op(op), .dec(dec), .rpt(rpt),
        .hl_in(hl_in), .de_in(de_in), .bc_in(bc_in), .a_in(a_in),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .io_addr(io_addr), .io_rd(io_rd), .io_rdata(io_rdata),
        .io_wr(io_wr), .io_wdata(io_wdata),
        .busy(busy), .done(done), .hl_out(hl_out), .de_out(de_out), .bc_out(bc_out),
        .match(match), .cnt_zero(cnt_zero), .tstates(tstates)
    );

    always #5 clk = ~clk;

    assign mem_rdata = mem[mem_addr[11:0]];
    assign io_rdata  = 8'hA0 + rd_idx[7:0];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
        if (int'(mem_rd) + int'(mem_wr) + int'(io_rd) + int'(io_wr) > 1)
            multi_strobe <= multi_strobe + 1;
        if (log_clr) begin
            io_n   <= 0;
            rd_idx <= 0;
        end else begin
            if (io_rd) begin
                port_log[io_n[8:0]] <= io_addr;
                io_n   <= io_n + 1;
                rd_idx <= rd_idx + 1;
            end
            if (io_wr) begin
                port_log[io_n[8:0]] <= io_addr;
                data_log[io_n[8:0]] <= io_wdata;
                io_n <= io_n + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] stp(input logic [15:0] a, input logic d);
        return d ? a - 16'd1 : a + 16'd1;
    endfunction

    // Independent model of the requirements, on the bench's own memory copy
    task automatic model(input logic [1:0] o, input logic d, input logic rp,
                         input logic [15:0] hl, input logic [15:0] de,
                         input logic [15:0] bc, input logic [7:0] a);
        logic more, m, cz;
        for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
        e_n = 0; e_t = '0; m = 1'b0;
        do begin
            m = 1'b0;
            case (o)
                2'd0: ref_mem[de[11:0]] = ref_mem[hl[11:0]];
                2'd1: m = (a == ref_mem[hl[11:0]]);
                2'd2: begin
                    if (e_n < 512) exp_port[e_n] = bc;
                    ref_mem[hl[11:0]] = 8'hA0 + e_n[7:0];
                end
                default: begin
                    if (e_n < 512) begin
                        exp_port[e_n] = bc;
                        exp_data[e_n] = ref_mem[hl[11:0]];
                    end
                end
            endcase
            hl = stp(hl, d);
            if (o == 2'd0) de = stp(de, d);
            if (o[1]) begin
                bc[15:8] = bc[15:8] - 8'd1;
                cz = (bc[15:8] == 8'd0);
            end else begin
                bc = bc - 16'd1;
                cz = (bc == 16'd0);
            end
            more = rp && !cz && !m;
            e_t = e_t + (more ? 24'd21 : 24'd16);
            e_n++;
        end while (more);
        e_hl = hl; e_de = de; e_bc = bc; e_match = m; e_cz = cz;
    endtask

    task automatic run_case(input logic [1:0] o, input logic d, input logic rp,
                            input logic [15:0] hl, input logic [15:0] de,
                            input logic [15:0] bc, input logic [7:0] a,
                            input string tag, input bit poke);
        string ot;
        bit ok;
        case (o)
            2'd0: ot = rp ? "R2 R3" : "R2";
            2'd1: ot = "R5";
            2'd2: ot = "R6";
            default: ot = "R7";
        endcase
        model(o, d, rp, hl, de, bc, a);
        @(negedge clk);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        op = o; dec = d; rpt = rp; hl_in = hl; de_in = de; bc_in = bc; a_in = a;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            op = 2'd3; hl_in = 16'h0123; bc_in = 16'h0101; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        chk(hl_out == e_hl, {ot, " hl ", tag}, 32'(hl_out), 32'(e_hl));
        chk(de_out == e_de, {ot, " de ", tag}, 32'(de_out), 32'(e_de));
        chk(bc_out == e_bc, {ot, " bc ", tag}, 32'(bc_out), 32'(e_bc));
        chk(tstates == e_t, {"R4 tstates ", tag}, 32'(tstates), 32'(e_t));
        chk(match == e_match, {"R10 R5 match ", tag}, 32'(match), 32'(e_match));
        chk(cnt_zero == e_cz, {"R10 cnt_zero ", tag}, 32'(cnt_zero), 32'(e_cz));
        ok = 1'b1;
        for (int i = 0; i < 4096; i++) if (mem[i] !== ref_mem[i]) ok = 1'b0;
        chk(ok, {ot, " memory image ", tag}, 32'(ok), 32'd1);
        if (o[1]) begin
            chk(io_n == e_n, {ot, " port access count ", tag}, 32'(io_n), 32'(e_n));
            ok = 1'b1;
            for (int k = 0; k < e_n && k < 512; k++) begin
                if (port_log[k] !== exp_port[k]) ok = 1'b0;
                if (o == 2'd3 && data_log[k] !== exp_data[k]) ok = 1'b0;
            end
            chk(ok, {ot, " port address/data log ", tag}, 32'(ok), 32'd1);
        end
        @(negedge clk);
        chk(!done, {"R10 done one cycle ", tag}, 32'(done), 32'd0);
    endtask

    initial begin
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                failures++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<190000", cyc);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] h, dd, b;
        logic [1:0]  o;
        logic [7:0]  av;
        void'($urandom(32'd20240611));
        multi_strobe = 0;
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        log_clr = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        log_clr = 1'b0;
        @(negedge clk);
        chk(!busy && !done, "R1 busy/done idle", 32'({busy, done}), 32'd0);
        chk(!(mem_rd || mem_wr || io_rd || io_wr), "R1 strobes idle",
            32'({mem_rd, mem_wr, io_rd, io_wr}), 32'd0);
        chk(tstates == 24'd0, "R1 tstates zero", 32'(tstates), 32'd0);

        // Directed corner cases
        run_case(2'd0, 1'b0, 1'b0, 16'h0100, 16'h0200, 16'h0005, 8'h00, "single copy", 1'b0);
        run_case(2'd0, 1'b0, 1'b1, 16'hFFFE, 16'hFFFF, 16'h0004, 8'h00, "R8 up wrap", 1'b0);
        run_case(2'd0, 1'b1, 1'b1, 16'h0001, 16'h0802, 16'h0003, 8'h00, "R8 down wrap", 1'b0);
        mem[12'h305] = 8'h5A;
        for (int i = 12'h300; i < 12'h305; i++) mem[i] = 8'h00;
        run_case(2'd1, 1'b0, 1'b1, 16'h0300, 16'h0000, 16'h0020, 8'h5A, "R5 early hit", 1'b0);
        run_case(2'd1, 1'b0, 1'b1, 16'h0300, 16'h0000, 16'h0003, 8'h5A, "R5 count out", 1'b0);
        run_case(2'd2, 1'b0, 1'b1, 16'h0400, 16'h0000, 16'h0512, 8'h00, "R6 repeat in", 1'b0);
        run_case(2'd3, 1'b1, 1'b1, 16'h0500, 16'h0000, 16'h0077, 8'h00, "R9 R7 256 outputs", 1'b0);
        run_case(2'd0, 1'b0, 1'b1, 16'h0600, 16'h0700, 16'h000A, 8'h00, "R11 start ignored", 1'b1);

        // Randomized operations
        for (int t = 0; t < 40; t++) begin
            o  = 2'($urandom);
            h  = 16'($urandom);
            dd = 16'($urandom);
            av = 8'($urandom);
            if (o[1]) b = {8'($urandom % 12 + 1), 8'($urandom)};
            else      b = 16'($urandom % 24 + 1);
            if (o == 2'd1 && $urandom % 2 == 1) av = mem[h[11:0] + 12'($urandom % 8)];
            run_case(o, 1'($urandom), 1'($urandom), h, dd, b, av, "random", 1'b0);
        end

        // Full 65536-iteration search with no possible match
        for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
        run_case(2'd1, 1'b0, 1'b1, 16'h1234, 16'h0000, 16'h0000, 8'h01, "R9 65536 compares", 1'b0);

        chk(multi_strobe == 0, "R12 strobe overlap count", 32'(multi_strobe), 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule